// File: doc/BRIEF.md
# Dependence-Steered FIFO Issue Queue

This block is an instruction scheduler that needs no associative window. Renamed micro-ops enter a small bank of in-order queues, and each queue collects a chain of mutually dependent operations. When a micro-op arrives, a steering stage checks two tables. A producer table records which queue holds the instruction that will write each physical tag. A ready table holds one bit per physical tag that says whether the value exists yet. From these the stage picks a queue for the newcomer: the queue whose newest entry produces one of its pending sources, or else an empty queue. If neither exists, dispatch stalls.

Only the head of each queue can issue. A head leaves when the ready table shows every source it uses as available. Up to two heads leave per cycle. Execution reports finished tags on a completion port, and each reported tag becomes ready and loses its producer mapping. Because completions are seen only through the registered ready table, a completion affects issue one cycle later. Reset is asynchronous and active-low, and its release passes through a two-flop synchronizer inside the block.

Top module: `dep_issue_steer`

## Requirements
- R1: After reset all queues are empty, nothing issues, every physical tag reads as ready and no tag has a producer queue. This holds even if reset is applied while queues are occupied.
- R2: A micro-op goes to queue q when one of its used sources is not ready, the producer table maps that source to q, and q's most recently pushed entry has that tag as destination. Queue q must also be able to accept the entry. Source 1 is checked before source 2. disp_q gives the chosen queue as a binary index.
- R3: If no producer queue qualifies, the micro-op goes to the lowest-indexed empty queue.
- R4: If no producer queue qualifies and no queue is empty, disp_ready is low, nothing is written and the micro-op may be offered again.
- R5: An accepted micro-op with a destination marks that tag not ready and maps it to the chosen queue. A consumer therefore waits on it.
- R6: A tag reported on cmp_valid/cmp_tag (slot k at bits [5k+4:5k]) becomes ready and loses its producer mapping at the next edge. It affects issue from the following cycle.
- R7: Only queue heads issue, and a head issues only when every source it uses is ready.
- R8: At most two heads issue per cycle, and ready heads are granted in ascending queue index. Issue slot k reports on iss_valid[k], iss_id[8k+7:8k] and iss_q[2k+1:2k], and slot 1 is used only when slot 0 is.
- R9: Within one queue, micro-ops issue in the order they were dispatched.
- R10: A full queue that pops a head in a cycle can accept a dispatched micro-op in that same cycle. A full queue that does not pop cannot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | A renamed micro-op is offered |
| disp_id | input | 8 | Micro-op identifier carried to issue |
| disp_s1_used | input | 1 | Source 1 is used |
| disp_s1 | input | 5 | Source 1 physical tag |
| disp_s2_used | input | 1 | Source 2 is used |
| disp_s2 | input | 5 | Source 2 physical tag |
| disp_d_used | input | 1 | A destination is written |
| disp_d | input | 5 | Destination physical tag |
| disp_ready | output | 1 | Steering found a queue; the offer is accepted when disp_valid is high |
| disp_q | output | 2 | Queue chosen by steering |
| cmp_valid | input | 2 | Completion slot valid bits |
| cmp_tag | input | 10 | Completed tags, 5 bits per slot |
| iss_valid | output | 2 | Issue slot valid bits |
| iss_id | output | 16 | Identifier per issue slot, 8 bits each |
| iss_q | output | 4 | Source queue per issue slot, 2 bits each |

## Verification
A corrupted ready bit or a stale producer mapping never shows at the ports directly. It shows the next time a consumer of that tag is offered. The consumer then lands in the wrong queue (disp_q), or a head that should wait appears on iss_valid a cycle early, or a ready head never appears at all. A lost queue entry or a broken pointer shows as a wrong iss_id or a wrong order of identifiers within one queue once that entry reaches the head. Queue-full and queue-empty mistakes show as disp_ready taking the wrong value in the cycle the offer is made. The stimulus therefore pairs each tag it makes pending with a later consumer and a later completion, so that every table entry it writes is read back through steering or issue within a few cycles.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int TAG_W   = 5;
  localparam int NUM_TAG = 1 << TAG_W;
  localparam int ID_W    = 8;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic             s1_v;
    logic [TAG_W-1:0] s1;
    logic             s2_v;
    logic [TAG_W-1:0] s2;
    logic             d_v;
    logic [TAG_W-1:0] d;
  } uop_t;
endpackage

// File: rtl/dis_fifo.sv
module dis_fifo
  import dis_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  uop_t din,
  output uop_t head,
  output logic empty,
  output logic full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  uop_t           mem [DEPTH];
  logic [PW-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = bump(wp_q);
    if (pop)  rp_d = bump(rp_q);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign head  = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  // R10: a full queue only takes a push while it pops
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push && full |-> pop);
  // R7: the selector never pops a queue that is empty
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/dis_tag_track.sv
module dis_tag_track
  import dis_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int CMP_W = 2,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_en,
  input  logic [TAG_W-1:0]              alloc_tag,
  input  logic [QW-1:0]                 alloc_q,
  input  logic [CMP_W-1:0]              cmp_valid,
  input  logic [CMP_W*TAG_W-1:0]        cmp_tag,
  output logic [NUM_TAG-1:0]            rdy,
  output logic [NUM_TAG-1:0]            prod_v,
  output logic [NUM_TAG-1:0][QW-1:0]    prod_q
);
  logic [NUM_TAG-1:0]         rdy_d, pv_d;
  logic [NUM_TAG-1:0][QW-1:0] pq_d;

  always_comb begin
    rdy_d = rdy;
    pv_d  = prod_v;
    pq_d  = prod_q;
    for (int k = 0; k < CMP_W; k++) begin
      if (cmp_valid[k]) begin
        rdy_d[cmp_tag[k*TAG_W +: TAG_W]] = 1'b1;
        pv_d[cmp_tag[k*TAG_W +: TAG_W]]  = 1'b0;
      end
    end
    if (alloc_en) begin
      rdy_d[alloc_tag] = 1'b0;
      pv_d[alloc_tag]  = 1'b1;
      pq_d[alloc_tag]  = alloc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy    <= '1;
      prod_v <= '0;
      prod_q <= '0;
    end else begin
      rdy    <= rdy_d;
      prod_v <= pv_d;
      prod_q <= pq_d;
    end
  end

  // R6: a completed tag reads ready after the edge unless reallocated
  assert_cmp_sets_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid[0] && !(alloc_en && alloc_tag == cmp_tag[TAG_W-1:0])
    |=> rdy[$past(cmp_tag[TAG_W-1:0])] && !prod_v[$past(cmp_tag[TAG_W-1:0])]);
  // R5: an allocated tag is pending and mapped to its queue
  assert_alloc_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> !rdy[$past(alloc_tag)] && prod_v[$past(alloc_tag)]
                 && prod_q[$past(alloc_tag)] == $past(alloc_q));
endmodule

// File: rtl/dis_steer.sv
module dis_steer
  import dis_pkg::*;
#(
  parameter int NUM_Q = 4,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  uop_t                          uop,
  input  logic [NUM_TAG-1:0]            rdy,
  input  logic [NUM_TAG-1:0]            prod_v,
  input  logic [NUM_TAG-1:0][QW-1:0]    prod_q,
  input  logic [NUM_Q-1:0]              q_empty,
  input  logic [NUM_Q-1:0]              q_full,
  input  logic [NUM_Q-1:0]              q_pop,
  input  logic [NUM_Q-1:0]              tail_v,
  input  logic [NUM_Q-1:0][TAG_W-1:0]   tail_d,
  output logic                          tgt_ok,
  output logic [QW-1:0]                 tgt_q
);
  logic [NUM_Q-1:0] can_take;
  logic [QW-1:0]    q1, q2, eq;
  logic             hit1, hit2, e_found;

  assign can_take = ~q_full | q_pop;

  always_comb begin
    q1   = prod_q[uop.s1];
    q2   = prod_q[uop.s2];
    hit1 = uop.s1_v && !rdy[uop.s1] && prod_v[uop.s1] && tail_v[q1]
           && (tail_d[q1] == uop.s1) && can_take[q1];
    hit2 = uop.s2_v && !rdy[uop.s2] && prod_v[uop.s2] && tail_v[q2]
           && (tail_d[q2] == uop.s2) && can_take[q2];
    e_found = 1'b0;
    eq      = '0;
    for (int q = NUM_Q - 1; q >= 0; q--) begin
      if (q_empty[q]) begin
        e_found = 1'b1;
        eq      = QW'(q);
      end
    end
    tgt_ok = hit1 || hit2 || e_found;
    tgt_q  = hit1 ? q1 : (hit2 ? q2 : eq);
  end
endmodule

// File: rtl/dis_issue_sel.sv
module dis_issue_sel #(
  parameter int NUM_Q   = 4,
  parameter int ISSUE_W = 2,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_Q-1:0]               head_ok,
  output logic [ISSUE_W-1:0]             slot_v,
  output logic [ISSUE_W-1:0][QW-1:0]     slot_q,
  output logic [NUM_Q-1:0]               pop
);
  logic [NUM_Q-1:0] taken;

  always_comb begin
    taken  = '0;
    slot_v = '0;
    slot_q = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      for (int q = 0; q < NUM_Q; q++) begin
        if (!slot_v[k] && head_ok[q] && !taken[q]) begin
          slot_v[k] = 1'b1;
          slot_q[k] = QW'(q);
          taken[q]  = 1'b1;
        end
      end
    end
  end

  assign pop = taken;

  generate
    if (ISSUE_W > 1) begin : g_order
      // R8: slot 1 only after slot 0, lower queue index in slot 0
      assert_slot_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_v[1] |-> slot_v[0] && (slot_q[0] < slot_q[1]));
    end
  endgenerate
  // R8: grants never exceed the issue width
  assert_issue_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pop) <= ISSUE_W);
endmodule

// File: rtl/dep_issue_steer.sv
module dep_issue_steer
  import dis_pkg::*;
#(
  parameter int NUM_Q   = 4,
  parameter int DEPTH   = 8,
  parameter int ISSUE_W = 2,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  input  logic [ID_W-1:0]          disp_id,
  input  logic                     disp_s1_used,
  input  logic [TAG_W-1:0]         disp_s1,
  input  logic                     disp_s2_used,
  input  logic [TAG_W-1:0]         disp_s2,
  input  logic                     disp_d_used,
  input  logic [TAG_W-1:0]         disp_d,
  output logic                     disp_ready,
  output logic [QW-1:0]            disp_q,
  input  logic [ISSUE_W-1:0]       cmp_valid,
  input  logic [ISSUE_W*TAG_W-1:0] cmp_tag,
  output logic [ISSUE_W-1:0]       iss_valid,
  output logic [ISSUE_W*ID_W-1:0]  iss_id,
  output logic [ISSUE_W*QW-1:0]    iss_q
);
  // reset: asserted at once, released after two clock edges
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  uop_t                        din;
  uop_t                        heads [NUM_Q];
  logic [NUM_Q-1:0]            q_empty, q_full, q_pop, push, head_ok;
  logic [NUM_TAG-1:0]          rdy, prod_v;
  logic [NUM_TAG-1:0][QW-1:0]  prod_q;
  logic [NUM_Q-1:0]            tail_v_q, tail_v_d;
  logic [NUM_Q-1:0][TAG_W-1:0] tail_d_q, tail_d_d;
  logic                        tgt_ok, disp_acc;
  logic [QW-1:0]               tgt_q;
  logic [ISSUE_W-1:0]          slot_v;
  logic [ISSUE_W-1:0][QW-1:0]  slot_q;

  always_comb begin
    din      = '0;
    din.id   = disp_id;
    din.s1_v = disp_s1_used;
    din.s1   = disp_s1;
    din.s2_v = disp_s2_used;
    din.s2   = disp_s2;
    din.d_v  = disp_d_used;
    din.d    = disp_d;
  end

  dis_steer #(.NUM_Q(NUM_Q)) u_steer (
    .uop(din), .rdy(rdy), .prod_v(prod_v), .prod_q(prod_q),
    .q_empty(q_empty), .q_full(q_full), .q_pop(q_pop),
    .tail_v(tail_v_q), .tail_d(tail_d_q),
    .tgt_ok(tgt_ok), .tgt_q(tgt_q)
  );

  assign disp_acc   = disp_valid && tgt_ok;
  assign disp_ready = tgt_ok;
  assign disp_q     = tgt_q;

  dis_tag_track #(.NUM_Q(NUM_Q), .CMP_W(ISSUE_W)) u_track (
    .clk(clk), .rst_n(rst_s),
    .alloc_en(disp_acc && disp_d_used), .alloc_tag(disp_d), .alloc_q(tgt_q),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .rdy(rdy), .prod_v(prod_v), .prod_q(prod_q)
  );

  generate
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      assign push[q] = disp_acc && (tgt_q == QW'(q));
      dis_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_s), .push(push[q]), .pop(q_pop[q]),
        .din(din), .head(heads[q]), .empty(q_empty[q]), .full(q_full[q])
      );
      assign head_ok[q] = !q_empty[q]
                          && (!heads[q].s1_v || rdy[heads[q].s1])
                          && (!heads[q].s2_v || rdy[heads[q].s2]);
    end
  endgenerate

  always_comb begin
    tail_v_d = tail_v_q;
    tail_d_d = tail_d_q;
    for (int q = 0; q < NUM_Q; q++) begin
      if (push[q]) begin
        tail_v_d[q] = disp_d_used;
        tail_d_d[q] = disp_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      tail_v_q <= '0;
      tail_d_q <= '0;
    end else begin
      tail_v_q <= tail_v_d;
      tail_d_q <= tail_d_d;
    end
  end

  dis_issue_sel #(.NUM_Q(NUM_Q), .ISSUE_W(ISSUE_W)) u_sel (
    .clk(clk), .rst_n(rst_s), .head_ok(head_ok),
    .slot_v(slot_v), .slot_q(slot_q), .pop(q_pop)
  );

  generate
    for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
      assign iss_valid[k]            = slot_v[k];
      assign iss_id[k*ID_W +: ID_W]  = slot_v[k] ? heads[slot_q[k]].id : '0;
      assign iss_q[k*QW +: QW]       = slot_q[k];
    end
  endgenerate

  // R2: a dispatch writes into exactly one queue
  assert_push_onehot_R2: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(push) && (disp_acc == (push != '0)));
  // R4: a stalled offer leaves the queues untouched
  assert_stall_no_push_R4: assert property (@(posedge clk) disable iff (!rst_s)
    disp_valid && !disp_ready |-> push == '0);
endmodule

// File: tb/test_dep_issue_steer.sv
module test_dep_issue_steer;
  logic        clk, rst_n;
  logic        disp_valid, s1u, s2u, du;
  logic [7:0]  disp_id;
  logic [4:0]  s1, s2, d;
  logic        disp_ready;
  logic [1:0]  disp_q;
  logic [1:0]  cmp_valid;
  logic [9:0]  cmp_tag;
  logic [1:0]  iss_valid;
  logic [15:0] iss_id;
  logic [3:0]  iss_q;

  int checks = 0;
  int fails  = 0;

  dep_issue_steer i_dep_issue_steer (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_id(disp_id),
    .disp_s1_used(s1u), .disp_s1(s1), .disp_s2_used(s2u), .disp_s2(s2),
    .disp_d_used(du), .disp_d(d), .disp_ready(disp_ready), .disp_q(disp_q),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .iss_valid(iss_valid), .iss_id(iss_id), .iss_q(iss_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic       dv;  logic [7:0] id;
    logic       s1v; logic [4:0] s1;
    logic       s2v; logic [4:0] s2;
    logic       ddv; logic [4:0] d;
    logic [1:0] cv;  logic [4:0] c0; logic [4:0] c1;
    logic       erdy; logic [1:0] eq;
    logic [1:0] eiv; logic [7:0] e0; logic [7:0] e1;
    logic [7:0] rq;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{1,1, 0,0, 0,0, 1,10, 0,0,0, 1,0, 0,0,0, 3},   // R3 first op, empty q0
    '{1,2, 1,10,0,0, 1,11, 0,0,0, 1,0, 1,1,0, 2},   // R2 behind producer; R10 push+pop
    '{1,3, 1,5, 0,0, 1,12, 0,0,0, 1,1, 0,0,0, 3},   // R3 ready src; R5 head 2 waits on 10
    '{1,4, 1,12,0,0, 1,13, 1,10,0, 1,1, 1,3,0, 2},  // R2; R6 completion not yet visible
    '{0,0, 0,0, 0,0, 0,0,  1,12,0, 0,0, 1,2,0, 6},  // R6 id2 now ready
    '{0,0, 0,0, 0,0, 0,0,  0,0,0, 0,0, 1,4,0, 9},   // R9 id4 after id3 in q1
    '{1,5, 1,11,0,0, 1,14, 0,0,0, 1,0, 0,0,0, 2},   // R2 tail of empty q0
    '{1,6, 1,13,0,0, 1,15, 0,0,0, 1,1, 0,0,0, 2},
    '{0,0, 0,0, 0,0, 0,0,  3,11,13, 0,0, 0,0,0, 6},
    '{0,0, 0,0, 0,0, 0,0,  0,0,0, 0,0, 3,5,6, 8},   // R8 dual issue
    '{1,7, 1,14,0,0, 1,16, 0,0,0, 1,0, 0,0,0, 2},
    '{1,8, 1,15,0,0, 1,17, 0,0,0, 1,1, 0,0,0, 2},
    '{1,9, 1,14,1,15, 1,18, 0,0,0, 1,2, 0,0,0, 3},  // R3 producers not at tails
    '{0,0, 0,0, 0,0, 0,0,  3,14,15, 0,0, 0,0,0, 7},  // R7 heads wait
    '{0,0, 0,0, 0,0, 0,0,  0,0,0, 0,0, 3,7,8, 8},   // R8 q0,q1 before q2
    '{0,0, 0,0, 0,0, 0,0,  0,0,0, 0,0, 1,9,0, 8},
    '{1,10,1,16,0,0, 1,20, 0,0,0, 1,0, 0,0,0, 2},
    '{1,11,1,16,0,0, 1,21, 0,0,0, 1,1, 0,0,0, 3},
    '{1,12,1,16,0,0, 1,22, 0,0,0, 1,2, 0,0,0, 3},
    '{1,13,1,16,0,0, 1,23, 0,0,0, 1,3, 0,0,0, 3},
    '{1,14,1,16,0,0, 1,24, 0,0,0, 0,0, 0,0,0, 4},   // R4 stall
    '{1,14,1,16,0,0, 1,24, 1,16,0, 0,0, 0,0,0, 4},
    '{1,14,1,16,0,0, 1,24, 0,0,0, 0,0, 3,10,11, 4},  // R4 pops do not free an empty slot
    '{1,14,1,16,0,0, 1,24, 0,0,0, 1,0, 3,12,13, 3},
    '{0,0, 0,0, 0,0, 0,0,  0,0,0, 0,0, 1,14,0, 7},
    '{1,20,1,24,0,0, 1,1, 0,0,0, 1,0, 0,0,0, 2},
    '{1,21,1,1, 0,0, 1,2, 0,0,0, 1,0, 0,0,0, 2},
    '{1,22,1,2, 0,0, 1,3, 0,0,0, 1,0, 0,0,0, 2},
    '{1,23,1,3, 0,0, 1,4, 0,0,0, 1,0, 0,0,0, 2},
    '{1,24,1,4, 0,0, 1,5, 0,0,0, 1,0, 0,0,0, 2},
    '{1,25,1,5, 0,0, 1,6, 0,0,0, 1,0, 0,0,0, 2},
    '{1,26,1,6, 0,0, 1,7, 0,0,0, 1,0, 0,0,0, 2},
    '{1,27,1,7, 0,0, 1,8, 0,0,0, 1,0, 0,0,0, 2},
    '{1,28,1,8, 0,0, 1,9, 0,0,0, 1,1, 0,0,0, 10},   // R10 full q0, no pop
    '{0,0, 0,0, 0,0, 0,0,  1,24,0, 0,0, 0,0,0, 6},
    '{1,29,1,8, 0,0, 1,10, 0,0,0, 1,0, 1,20,0, 10}  // R10 full q0 popping
  };

  task automatic chk(input bit ok, input int rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    disp_valid = 0; disp_id = 0; s1u = 0; s1 = 0; s2u = 0; s2 = 0;
    du = 0; d = 0; cmp_valid = 0; cmp_tag = 0;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    disp_valid = v.dv; disp_id = v.id; s1u = v.s1v; s1 = v.s1;
    s2u = v.s2v; s2 = v.s2; du = v.ddv; d = v.d;
    cmp_valid = v.cv; cmp_tag = {v.c1, v.c0};
    #2;
    if (v.dv) begin
      chk(disp_ready == v.erdy, int'(v.rq), "disp_ready", disp_ready, v.erdy);
      if (v.erdy) chk(disp_q == v.eq, int'(v.rq), "disp_q", disp_q, v.eq);
    end
    chk(iss_valid == v.eiv, int'(v.rq), "iss_valid", iss_valid, v.eiv);
    if (v.eiv[0]) chk(iss_id[7:0] == v.e0, int'(v.rq), "iss_id0", iss_id[7:0], v.e0);
    if (v.eiv[1]) chk(iss_id[15:8] == v.e1, int'(v.rq), "iss_id1", iss_id[15:8], v.e1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    do_reset();
    // R1: reset state seen at the ports
    #2;
    chk(iss_valid == 2'b00, 1, "iss_valid after reset", iss_valid, 0);
    chk(disp_ready == 1'b1, 1, "disp_ready after reset", disp_ready, 1);
    chk(disp_q == 2'd0, 1, "disp_q after reset", disp_q, 0);

    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // R1: reset while q0 and q1 hold waiting ops and tag 8 is pending
    do_reset();
    apply('{1,40, 1,8, 0,0, 1,3, 0,0,0, 1,0, 0,0,0, 1});
    apply('{0,0, 0,0, 0,0, 0,0, 0,0,0, 0,0, 1,40,0, 1});
    @(negedge clk);
    idle_inputs();
    #2;
    chk(iss_valid == 2'b00, 1, "queues drained after reset", iss_valid, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule